// File: doc/BRIEF.md
# USB Start-of-Frame Interval Timer

This block paces the frames of a full-speed USB host. It is a small register-mapped peripheral clocked at 12 MHz. Software loads a 14-bit reload value through two byte registers and then sets a run bit. A down-counter then produces a one-cycle frame tick each time it expires and reloads itself. An 11-bit frame number advances on every tick. Software reads the high reload address to see the live remaining count, coarsened by a divide-by-64, and uses it to judge how much of the current frame is left before it starts a transfer.

Writing the high reload address does four things. It stores the upper reload bits and sets the line-polarity-swap and host-role outputs. It clears the frame number. It also latches a sticky extended-feature enable that stays set until reset.

The timer is a four-state machine with these states:
- STOP: idle; the count is held.
- LOAD: one cycle that copies the reload value into the counter.
- COUNT: the counter decrements once per clock.
- EXPIRE: the count is zero. The tick is asserted and the counter reloads.

It has these transitions:
- STOP→LOAD: the run bit is written to 1 while the timer is stopped.
- LOAD→COUNT: always, after one cycle.
- COUNT→EXPIRE: the count is 1 or 0.
- EXPIRE→COUNT: always, after one cycle.
- any state→STOP: the run bit is written to 0.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset, every register reads 0x00, frame_num, pol_swap, host_mode and ext_feat_en are 0, and no frame_tick occurs while the run bit is 0.
- R2: Address 0x0E holds the low 8 reload bits, and a read of 0x0E returns the stored byte, never the live count.
- R3: A write to 0x0F stores bits 5:0 as reload bits 13:8. Bit 6 drives pol_swap (1 = swapped) and bit 7 drives host_mode (1 = host), both from the cycle after the write.
- R4: A write to 0x0F sets frame_num to 0 in the following cycle. This takes priority over a frame tick in the same cycle.
- R5: A write to 0x0F sets ext_feat_en, which then stays 1 until reset.
- R6: Writing 1 to bit 0 of 0x05 while the timer is stopped starts a fresh frame. With reload value R ≥ 1, frame_tick goes high R+1 cycles after the write edge and then every R+1 cycles, each time for exactly one cycle.
- R7: frame_num rises by one in the cycle after each frame_tick and wraps from 2047 to 0.
- R8: A read of 0x0F returns bits 13:6 of the live down-counter. During a frame this is (R−m)>>6, where m counts cycles since the counter was loaded.
- R9: Writing 0 to bit 0 of 0x05 stops the countdown. The count and frame_num are then held and no tick occurs.
- R10: A read of 0x05 returns the run bit in bit 0 with zeros above it. A read of any other unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register address, used for both reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| frame_tick | output | 1 | One-cycle pulse when the frame counter expires |
| frame_num | output | 11 | Current frame number |
| pol_swap | output | 1 | Data-line polarity swap select |
| host_mode | output | 1 | 1 = host role, 0 = device role |
| ext_feat_en | output | 1 | Sticky extended-feature enable |

## Verification
The hardest situation to reach from the ports is a write to 0x0F that lands on the same edge as an expiry. Here the frame clear must beat the increment. The bench gets there by using a reload of 1, so that every other cycle is an expiry, and by issuing the write at the very sample where it sees the tick. The coarse count read is swept over every cycle of a full 12000-count frame and compared with (R−m)>>6. The frame wrap is reached by running 2048 two-cycle frames.

// File: rtl/uft_pkg.sv
package uft_pkg;
    localparam int UFT_CNT_W = 14;
    localparam int UFT_FRM_W = 11;
    localparam int UFT_DW    = 8;
    localparam int UFT_AW    = 8;

    localparam logic [UFT_AW-1:0] ADDR_CTRL   = 8'h05;
    localparam logic [UFT_AW-1:0] ADDR_RLD_LO = 8'h0E;
    localparam logic [UFT_AW-1:0] ADDR_RLD_HI = 8'h0F;

    typedef enum logic [1:0] {
        ST_STOP   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_COUNT  = 2'd2,
        ST_EXPIRE = 2'd3
    } tmr_state_e;
endpackage

// File: rtl/uft_regs.sv
module uft_regs
    import uft_pkg::*;
#(
    parameter int CNT_W = UFT_CNT_W,
    parameter int DW    = UFT_DW,
    parameter int AW    = UFT_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic             wr,
    output logic [CNT_W-1:0] reload,
    output logic             run_q,
    output logic             pol_swap,
    output logic             host_mode,
    output logic             ext_feat_en,
    output logic             start_req,
    output logic             stop_req,
    output logic             hi_wr
);
    localparam int HI_W = CNT_W - DW;

    logic [DW-1:0]   lo_q;
    logic [HI_W-1:0] hi_q;
    logic            lo_wr;
    logic            ctrl_wr;

    always_comb begin
        lo_wr     = wr && (addr == ADDR_RLD_LO);
        hi_wr     = wr && (addr == ADDR_RLD_HI);
        ctrl_wr   = wr && (addr == ADDR_CTRL);
        start_req = ctrl_wr && wdata[0] && !run_q;
        stop_req  = ctrl_wr && !wdata[0];
        reload    = {hi_q, lo_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q        <= '0;
            hi_q        <= '0;
            run_q       <= 1'b0;
            pol_swap    <= 1'b0;
            host_mode   <= 1'b0;
            ext_feat_en <= 1'b0;
        end else begin
            if (lo_wr) lo_q <= wdata;
            if (hi_wr) begin
                hi_q        <= wdata[HI_W-1:0];
                pol_swap    <= wdata[HI_W];
                host_mode   <= wdata[HI_W+1];
                ext_feat_en <= 1'b1;
            end
            if (ctrl_wr) run_q <= wdata[0];
        end
    end
endmodule

// File: rtl/uft_fsm.sv
module uft_fsm
    import uft_pkg::*;
#(
    parameter int CNT_W = UFT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt_q,
    output logic             tick
);
    tmr_state_e state_q, state_d;
    logic       load_en;
    logic       dec_en;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:   if (start_req) state_d = ST_LOAD;
            ST_LOAD:   state_d = ST_COUNT;
            ST_COUNT:  if (cnt_q <= CNT_W'(1)) state_d = ST_EXPIRE;
            ST_EXPIRE: state_d = ST_COUNT;
            default:   state_d = ST_STOP;
        endcase
        if (stop_req) state_d = ST_STOP;
    end

    // outputs
    always_comb begin
        tick    = (state_q == ST_EXPIRE);
        load_en = (state_q == ST_LOAD) || (state_q == ST_EXPIRE);
        dec_en  = (state_q == ST_COUNT) && (cnt_q != '0);
    end

    // counter datapath
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (stop_req) cnt_q <= cnt_q;
        else if (load_en)  cnt_q <= reload;
        else if (dec_en)   cnt_q <= cnt_q - CNT_W'(1);
    end
endmodule

// File: rtl/uft_frame_ctr.sv
module uft_frame_ctr
    import uft_pkg::*;
#(
    parameter int FRM_W = UFT_FRM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    output logic [FRM_W-1:0] frame_num
);
    always_ff @(posedge clk) begin
        if (!rst_n)    frame_num <= '0;
        else if (clr)  frame_num <= '0;
        else if (tick) frame_num <= frame_num + FRM_W'(1);
    end
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
    import uft_pkg::*;
#(
    parameter int CNT_W = UFT_CNT_W,
    parameter int FRM_W = UFT_FRM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             reg_wr,
    output logic [7:0]       reg_rdata,
    output logic             frame_tick,
    output logic [FRM_W-1:0] frame_num,
    output logic             pol_swap,
    output logic             host_mode,
    output logic             ext_feat_en
);
    localparam int DW    = 8;
    localparam int SHIFT = CNT_W - DW;

    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q, start_req, stop_req, hi_wr;

    uft_regs #(.CNT_W(CNT_W), .DW(DW), .AW(8)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata), .wr(reg_wr),
        .reload(reload), .run_q(run_q), .pol_swap(pol_swap), .host_mode(host_mode),
        .ext_feat_en(ext_feat_en), .start_req(start_req), .stop_req(stop_req),
        .hi_wr(hi_wr)
    );

    uft_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .reload(reload), .cnt_q(cnt_q), .tick(frame_tick)
    );

    uft_frame_ctr #(.FRM_W(FRM_W)) u_frm (
        .clk(clk), .rst_n(rst_n), .tick(frame_tick), .clr(hi_wr),
        .frame_num(frame_num)
    );

    always_comb begin
        case (reg_addr)
            ADDR_CTRL:   reg_rdata = {7'd0, run_q};
            ADDR_RLD_LO: reg_rdata = reload[DW-1:0];
            ADDR_RLD_HI: reg_rdata = cnt_q[CNT_W-1:SHIFT];
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uft_checks.sv
module uft_checks #(
    parameter int FRM_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       reg_addr,
    input logic [7:0]       reg_wdata,
    input logic             reg_wr,
    input logic             frame_tick,
    input logic [FRM_W-1:0] frame_num,
    input logic             pol_swap,
    input logic             host_mode,
    input logic             ext_feat_en
);
    logic hi_write;
    assign hi_write = reg_wr && (reg_addr == 8'h0F);

    // R6
    tick_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> !frame_tick);

    // R7
    frame_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !hi_write) |=> (frame_num == $past(frame_num) + FRM_W'(1)));

    // R9
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_tick && !hi_write) |=> $stable(frame_num));

    // R4
    frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_write |=> (frame_num == '0));

    // R5
    feat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_feat_en |=> ext_feat_en);

    // R5
    feat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_write |=> ext_feat_en);

    // R3
    mode_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_write |=> (pol_swap == $past(reg_wdata[6]) && host_mode == $past(reg_wdata[7])));
endmodule

bind usb_frame_timer uft_checks #(.FRM_W(FRM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .frame_tick(frame_tick), .frame_num(frame_num),
    .pol_swap(pol_swap), .host_mode(host_mode), .ext_feat_en(ext_feat_en)
);

// File: tb/usb_frame_timer_test.sv
module usb_frame_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_rdata;
    logic        frame_tick;
    logic [10:0] frame_num;
    logic        pol_swap, host_mode, ext_feat_en;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    usb_frame_timer uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .frame_tick(frame_tick),
        .frame_num(frame_num), .pol_swap(pol_swap), .host_mode(host_mode),
        .ext_feat_en(ext_feat_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; write lands on the next posedge
    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!frame_tick && n < 20000);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        reg_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int v, n, ticks, held, fnum;
        do_reset();

        // R1 reset state
        check("R1 frame_num", int'(frame_num), 0);
        check("R1 pol_swap", int'(pol_swap), 0);
        check("R1 host_mode", int'(host_mode), 0);
        check("R1 ext_feat_en", int'(ext_feat_en), 0);
        rd_reg(8'h05, v); check("R1 ctrl read", v, 0);
        rd_reg(8'h0E, v); check("R1 lo read", v, 0);
        rd_reg(8'h0F, v); check("R1 hi read", v, 0);
        ticks = 0;
        repeat (20) begin @(negedge clk); if (frame_tick) ticks++; end
        check("R1 no tick while stopped", ticks, 0);
        rd_reg(8'h33, v); check("R10 unmapped read", v, 0);

        // R2 low byte storage
        wr_reg(8'h0E, 8'hA5);
        rd_reg(8'h0E, v); check("R2 lo readback", v, 8'hA5);

        // R3 / R5 mode bits and feature enable
        wr_reg(8'h0F, 8'hC0);
        check("R3 pol_swap set", int'(pol_swap), 1);
        check("R3 host_mode set", int'(host_mode), 1);
        check("R5 ext_feat_en set", int'(ext_feat_en), 1);
        rd_reg(8'h0F, v); check("R8 stopped count read", v, 0);

        // R6 / R7 period sweep over small reload values
        for (int r = 1; r <= 12; r++) begin
            wr_reg(8'h0E, 8'(r));
            wr_reg(8'h0F, 8'h40);
            check("R3 host_mode clear", int'(host_mode), 0);
            check("R4 frame cleared", int'(frame_num), 0);
            wr_reg(8'h05, 8'h01);
            rd_reg(8'h05, v); check("R10 run bit read", v, 1);
            wait_tick(n); check("R6 first period", n, r + 1);
            @(negedge clk); check("R6 tick width", int'(frame_tick), 0);
            check("R7 frame after first tick", int'(frame_num), 1);
            wait_tick(n); check("R6 later period", n, r);
            check("R7 frame before second increment", int'(frame_num), 1);
            rd_reg(8'h0E, v); check("R2 lo not live", v, r);
            wr_reg(8'h05, 8'h00);
            fnum = int'(frame_num);
            check("R7 frame after second tick", fnum, 2);
            ticks = 0;
            repeat (30) begin @(negedge clk); if (frame_tick) ticks++; end
            check("R9 no tick after stop", ticks, 0);
            check("R9 frame held", int'(frame_num), fnum);
        end

        // R4 priority: clear on the same edge as an expiry
        wr_reg(8'h0E, 8'h01);
        wr_reg(8'h0F, 8'h00);
        wr_reg(8'h05, 8'h01);
        wait_tick(n);
        wait_tick(n);
        check("R4 frame before collide", int'(frame_num), 1);
        wr_reg(8'h0F, 8'h00);
        check("R4 clear beats tick", int'(frame_num), 0);
        wr_reg(8'h05, 8'h00);

        // R7 wrap
        wr_reg(8'h0F, 8'h00);
        wr_reg(8'h05, 8'h01);
        for (int i = 0; i < 2047; i++) wait_tick(n);
        @(negedge clk); check("R7 frame at 2047", int'(frame_num), 2047);
        wait_tick(n);
        @(negedge clk); check("R7 frame wraps", int'(frame_num), 0);
        wr_reg(8'h05, 8'h00);

        // R8 exhaustive coarse count over a 12000-count frame
        wr_reg(8'h0E, 8'hE0);
        wr_reg(8'h0F, 8'h2E);
        wr_reg(8'h05, 8'h01);
        @(negedge clk);
        for (int m = 0; m < 12000; m++) begin
            rd_reg(8'h0F, v);
            check("R8 coarse count", v, (12000 - m) >> 6);
            @(negedge clk);
        end
        check("R6 tick at end of long frame", int'(frame_tick), 1);
        rd_reg(8'h0F, v); check("R8 count zero at expiry", v, 0);
        @(negedge clk);
        rd_reg(8'h0F, v); check("R8 reload after expiry", v, 187);
        check("R7 frame after long frame", int'(frame_num), 1);

        // R9 stop holds the count
        repeat (100) @(negedge clk);
        rd_reg(8'h0F, held);
        wr_reg(8'h05, 8'h00);
        rd_reg(8'h05, v); check("R10 run bit cleared", v, 0);
        ticks = 0;
        repeat (300) begin @(negedge clk); if (frame_tick) ticks++; end
        rd_reg(8'h0F, v); check("R9 count held", v, held);
        check("R9 no tick when held", ticks, 0);
        check("R9 frame held", int'(frame_num), 1);

        // R6 restart gives a fresh frame
        wr_reg(8'h05, 8'h01);
        @(negedge clk);
        rd_reg(8'h0F, v); check("R6 fresh frame on restart", v, 187);

        // R5 sticky until reset
        wr_reg(8'h0E, 8'h10);
        check("R5 ext_feat_en sticky", int'(ext_feat_en), 1);
        do_reset();
        check("R5 ext_feat_en cleared by reset", int'(ext_feat_en), 0);
        rd_reg(8'h0E, v); check("R1 lo after reset", v, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule